// File: doc/BRIEF.md
# Compact register-format extend and jump unit

This unit executes one 16-bit compact instruction of register format. The format names a single register through a 3-bit field. The unit handles in-place sign extension and zero extension of that register at byte, halfword and word width, along with three register-indirect jumps that have no delay slot. The instruction is split from the top bit down into four fields: a 5-bit major opcode that must equal 11101, the 3-bit register field, a 3-bit sub-op and a 5-bit function. Function 10001 selects the extend group and function 00000 selects the jump group.

The front of the pipeline drives `issue` together with the instruction word. The register field is presented combinationally on `rd_idx`, and the register file returns the value on `rd_data`. The unit decodes and computes in the same cycle and then registers the outcome. During the next cycle, exactly one of these is presented: a register write-back, a branch (optionally with a return-address write), or an illegal-instruction flag. Word-width extends are legal only while `mode64` is high.

The result stage is a small state machine with five states: RK_IDLE, RK_WRITE, RK_JUMP, RK_LINKJUMP and RK_TRAP.
- Every clock edge picks the next state from the current decode.
- An issued extend moves to RK_WRITE.
- A plain jump, or a jump through the return address, moves to RK_JUMP.
- A jump-and-link moves to RK_LINKJUMP.
- Any illegal encoding under the major opcode moves to RK_TRAP.
- If nothing is issued, or the major opcode differs, the next state is RK_IDLE.
- Each non-idle state lasts one cycle unless it is re-entered.
- Reset forces RK_IDLE.

Top module: `cmp_rr_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `wb_en`, `br_take`, `ra_we` and `illegal` are all 0.
- R2: Function 10001 with sub-op 100 writes back the register sign-extended from bit 7. Sub-op 101 sign-extends from bit 15.
- R3: Function 10001 with sub-op 000 writes back the register with every bit above bit 7 cleared. Sub-op 001 clears every bit above bit 15.
- R4: `rd_idx` always equals instruction bits 10:8. The result of an issued instruction appears in the cycle after the issuing edge, for that one cycle only. `wb_idx` equals the register field of the instruction.
- R5: With `mode64` high, sub-op 010 clears every bit above bit 31 and sub-op 110 sign-extends from bit 31 (function 10001).
- R6: With `mode64` low, sub-ops 010 and 110 under function 10001 raise `illegal` and produce no write-back.
- R7: Function 00000 with sub-op 100 raises `br_take`, with `br_target` equal to the register value and no return-address write.
- R8: Function 00000 with sub-op 101 and register field 000 raises `br_take`, with `br_target` equal to `ra_val`.
- R9: Function 00000 with sub-op 110 raises `br_take` with the register value as target. It also raises `ra_we`, with `ra_wdata` equal to the `next_pc` sampled at issue.
- R10: Any other sub-op/function combination under major opcode 11101 raises `illegal` only. Examples are sub-op 011 or 111 with function 10001, sub-op 101 with a non-zero register field, and any other function value.
- R11: An instruction with a different major opcode, or any cycle with `issue` low, produces no write-back, branch, link or illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction on `instr` is to be executed this cycle |
| instr | input | 16 | Compact instruction word |
| mode64 | input | 1 | 64-bit operation enabled |
| next_pc | input | XLEN | Address of the following instruction |
| rd_idx | output | 3 | Register read index (register field) |
| rd_data | input | XLEN | Value of the register named by `rd_idx` |
| ra_val | input | XLEN | Current return-address register value |
| wb_en | output | 1 | Register write-back enable |
| wb_idx | output | 3 | Register write-back index |
| wb_data | output | XLEN | Register write-back data |
| ra_we | output | 1 | Return-address register write enable |
| ra_wdata | output | XLEN | Return-address write data |
| br_take | output | 1 | Redirect the next fetch |
| br_target | output | XLEN | Next fetch address |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The hardest cases to reach are the encodings that sit one field away from a legal one. Examples are a word-width extend issued while `mode64` is low, a return-address jump with a non-zero register field, and the two unused extend sub-ops. Any of these could silently fall into a neighbouring legal case. The stimulus table places each of these next to its legal twin, toggling only `mode64` or one field. Register values are chosen with the bit just below each extension boundary set opposite to the sign bit, so that a wrong boundary changes the written value.

// File: rtl/crr_pkg.sv
package crr_pkg;

    localparam int INSN_W    = 16;
    localparam int REG_IDX_W = 3;
    localparam int SUB_W     = 3;
    localparam int FN_W      = 5;
    localparam int MAJ_W     = INSN_W - REG_IDX_W - SUB_W - FN_W;

    // field positions derived from the widths, function field at the bottom
    localparam int FN_LSB  = 0;
    localparam int SUB_LSB = FN_LSB + FN_W;
    localparam int REG_LSB = SUB_LSB + SUB_W;
    localparam int MAJ_LSB = REG_LSB + REG_IDX_W;

    localparam logic [MAJ_W-1:0] MAJOR_RR = 5'b11101;
    localparam logic [FN_W-1:0]  FN_EXT   = 5'b10001;
    localparam logic [FN_W-1:0]  FN_JMP   = 5'b00000;

    localparam logic [SUB_W-1:0] SUB_JR   = 3'b100;
    localparam logic [SUB_W-1:0] SUB_JRRA = 3'b101;
    localparam logic [SUB_W-1:0] SUB_JALR = 3'b110;

    localparam int N_EXT_W = 3;

    typedef enum logic [1:0] {
        EW_BYTE = 2'd0,
        EW_HALF = 2'd1,
        EW_WORD = 2'd2
    } ext_width_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ZEXT,
        OP_SEXT,
        OP_JR,
        OP_JRRA,
        OP_JALR,
        OP_BAD
    } op_e;

    typedef struct packed {
        op_e                  op;
        ext_width_e           width;
        logic [REG_IDX_W-1:0] reg_idx;
    } dec_t;

    typedef enum logic [2:0] {
        RK_IDLE,
        RK_WRITE,
        RK_JUMP,
        RK_LINKJUMP,
        RK_TRAP
    } res_kind_e;

endpackage

// File: rtl/crr_decode.sv
module crr_decode
    import crr_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic              mode64,
    output dec_t              dec
);

    logic [MAJ_W-1:0]     major;
    logic [REG_IDX_W-1:0] rfield;
    logic [SUB_W-1:0]     sub;
    logic [FN_W-1:0]      fn;

    always_comb begin
        major = insn[MAJ_LSB +: MAJ_W];
        rfield = insn[REG_LSB +: REG_IDX_W];
        sub = insn[SUB_LSB +: SUB_W];
        fn = insn[FN_LSB +: FN_W];
    end

    always_comb begin
        dec.reg_idx = rfield;
        dec.width = EW_BYTE;
        dec.op = OP_NONE;
        if (major == MAJOR_RR) begin
            dec.op = OP_BAD;
            unique case (fn)
                FN_EXT: begin
                    // low two sub-op bits give the width, the top bit the signedness
                    if (sub[1:0] != 2'b11) begin
                        dec.width = ext_width_e'(sub[1:0]);
                        if ((sub[1:0] != 2'b10) || mode64) begin
                            dec.op = sub[2] ? OP_SEXT : OP_ZEXT;
                        end
                    end
                end
                FN_JMP: begin
                    unique case (sub)
                        SUB_JR:   dec.op = OP_JR;
                        SUB_JRRA: dec.op = (rfield == '0) ? OP_JRRA : OP_BAD;
                        SUB_JALR: dec.op = OP_JALR;
                        default:  dec.op = OP_BAD;
                    endcase
                end
                default: dec.op = OP_BAD;
            endcase
        end
    end

endmodule

// File: rtl/crr_extend.sv
module crr_extend
    import crr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] src,
    input  ext_width_e      width,
    input  logic            sign_ext,
    output logic [XLEN-1:0] result
);

    logic [XLEN-1:0] zx [N_EXT_W];
    logic [XLEN-1:0] sx [N_EXT_W];

    for (genvar g = 0; g < N_EXT_W; g++) begin : g_w
        localparam int FW = 8 << g;
        if (FW < XLEN) begin : g_cut
            assign zx[g] = {{(XLEN-FW){1'b0}}, src[FW-1:0]};
            assign sx[g] = {{(XLEN-FW){src[FW-1]}}, src[FW-1:0]};
        end else begin : g_full
            assign zx[g] = src;
            assign sx[g] = src;
        end
    end

    always_comb begin
        unique case (width)
            EW_BYTE: result = sign_ext ? sx[0] : zx[0];
            EW_HALF: result = sign_ext ? sx[1] : zx[1];
            EW_WORD: result = sign_ext ? sx[2] : zx[2];
            default: result = src;
        endcase
    end

endmodule

// File: rtl/crr_target.sv
module crr_target
    import crr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  op_e             op,
    input  logic [XLEN-1:0] reg_val,
    input  logic [XLEN-1:0] ra_val,
    input  logic [XLEN-1:0] next_pc,
    output logic            take,
    output logic            link,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] link_val
);

    always_comb begin
        take = 1'b0;
        link = 1'b0;
        target = reg_val;
        link_val = next_pc;
        unique case (op)
            OP_JR: take = 1'b1;
            OP_JRRA: begin
                take = 1'b1;
                target = ra_val;
            end
            OP_JALR: begin
                take = 1'b1;
                link = 1'b1;
            end
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmp_rr_unit.sv
module cmp_rr_unit
    import crr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [INSN_W-1:0]    instr,
    input  logic                 mode64,
    input  logic [XLEN-1:0]      next_pc,
    output logic [REG_IDX_W-1:0] rd_idx,
    input  logic [XLEN-1:0]      rd_data,
    input  logic [XLEN-1:0]      ra_val,
    output logic                 wb_en,
    output logic [REG_IDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]      wb_data,
    output logic                 ra_we,
    output logic [XLEN-1:0]      ra_wdata,
    output logic                 br_take,
    output logic [XLEN-1:0]      br_target,
    output logic                 illegal
);

    dec_t            dec;
    logic [XLEN-1:0] ext_res;
    logic            tgt_take;
    logic            tgt_link;
    logic [XLEN-1:0] tgt_addr;
    logic [XLEN-1:0] tgt_link_val;

    res_kind_e            kind_q, kind_d;
    logic [XLEN-1:0]      data_q, data_d;
    logic [XLEN-1:0]      link_q;
    logic [REG_IDX_W-1:0] idx_q;

    crr_decode u_decode (
        .insn   (instr),
        .mode64 (mode64),
        .dec    (dec)
    );

    crr_extend #(.XLEN(XLEN)) u_extend (
        .src      (rd_data),
        .width    (dec.width),
        .sign_ext (dec.op == OP_SEXT),
        .result   (ext_res)
    );

    crr_target #(.XLEN(XLEN)) u_target (
        .op       (dec.op),
        .reg_val  (rd_data),
        .ra_val   (ra_val),
        .next_pc  (next_pc),
        .take     (tgt_take),
        .link     (tgt_link),
        .target   (tgt_addr),
        .link_val (tgt_link_val)
    );

    assign rd_idx = dec.reg_idx;

    // next-state selection
    always_comb begin
        kind_d = RK_IDLE;
        data_d = '0;
        if (issue) begin
            unique case (dec.op)
                OP_ZEXT, OP_SEXT: begin
                    kind_d = RK_WRITE;
                    data_d = ext_res;
                end
                OP_JR, OP_JRRA, OP_JALR: begin
                    kind_d = (tgt_link && tgt_take) ? RK_LINKJUMP : RK_JUMP;
                    data_d = tgt_addr;
                end
                OP_BAD:  kind_d = RK_TRAP;
                default: kind_d = RK_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= RK_IDLE;
            data_q <= '0;
            link_q <= '0;
            idx_q  <= '0;
        end else begin
            kind_q <= kind_d;
            data_q <= data_d;
            link_q <= tgt_link_val;
            idx_q  <= dec.reg_idx;
        end
    end

    // outputs from state
    always_comb begin
        wb_en     = 1'b0;
        br_take   = 1'b0;
        ra_we     = 1'b0;
        illegal   = 1'b0;
        wb_idx    = idx_q;
        wb_data   = data_q;
        br_target = data_q;
        ra_wdata  = link_q;
        unique case (kind_q)
            RK_IDLE:  ;
            RK_WRITE: wb_en = 1'b1;
            RK_JUMP:  br_take = 1'b1;
            RK_LINKJUMP: begin
                br_take = 1'b1;
                ra_we   = 1'b1;
            end
            RK_TRAP:  illegal = 1'b1;
            default:  ;
        endcase
    end

    // at most one kind of result per cycle
    p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en, br_take, illegal}));

    // word extend without 64-bit mode traps and never writes
    p_word_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && instr[MAJ_LSB +: MAJ_W] == MAJOR_RR && instr[FN_LSB +: FN_W] == FN_EXT
         && instr[SUB_LSB +: 2] == 2'b10 && !mode64) |=> (illegal && !wb_en));

    // idle issue gives no result next cycle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !(wb_en || br_take || ra_we || illegal));

    // write-back index follows the register field of the issuing instruction
    p_wb_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (!wb_en || wb_idx == $past(instr[REG_LSB +: REG_IDX_W])));

    // jump-and-link captures next address and jumps to register
    p_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && instr == {MAJOR_RR, instr[REG_LSB +: REG_IDX_W], SUB_JALR, FN_JMP})
        |=> (br_take && ra_we && ra_wdata == $past(next_pc) && br_target == $past(rd_data)));

    // return-address jump goes to the return-address value
    p_jrra_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && instr == {MAJOR_RR, 3'b000, SUB_JRRA, FN_JMP})
        |=> (br_take && !ra_we && br_target == $past(ra_val)));

endmodule

// File: tb/tb_cmp_rr_unit.sv
module tb_cmp_rr_unit;

    localparam int XLEN = 64;
    localparam logic [63:0] RA_V = 64'h0000_0000_0040_1000;
    localparam logic [63:0] NPC  = 64'h0000_0000_0040_0022;

    typedef struct packed {
        logic [4:0]  maj;
        logic [2:0]  rx;
        logic [2:0]  sub;
        logic [4:0]  fn;
        logic        m64;
        logic [63:0] rsv;
        logic [2:0]  ek;   // 0 none, 1 write, 2 jump, 3 link+jump, 4 trap
        logic [63:0] ed;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VT [NV] = '{
        '{5'b11101, 3'd3, 3'b100, 5'b10001, 1'b0, 64'h1234_5678_9ABC_DE80, 3'd1, 64'hFFFF_FFFF_FFFF_FF80}, // R2
        '{5'b11101, 3'd2, 3'b100, 5'b10001, 1'b0, 64'hFFFF_FFFF_FFFF_FF7F, 3'd1, 64'h0000_0000_0000_007F}, // R2
        '{5'b11101, 3'd5, 3'b101, 5'b10001, 1'b0, 64'h0000_0000_0000_8001, 3'd1, 64'hFFFF_FFFF_FFFF_8001}, // R2
        '{5'b11101, 3'd5, 3'b101, 5'b10001, 1'b1, 64'hFFFF_0000_1234_7FFF, 3'd1, 64'h0000_0000_0000_7FFF}, // R2
        '{5'b11101, 3'd1, 3'b000, 5'b10001, 1'b0, 64'hFFFF_FFFF_FFFF_FFA5, 3'd1, 64'h0000_0000_0000_00A5}, // R3
        '{5'b11101, 3'd7, 3'b001, 5'b10001, 1'b1, 64'h8000_0000_0001_C3C3, 3'd1, 64'h0000_0000_0000_C3C3}, // R3
        '{5'b11101, 3'd4, 3'b010, 5'b10001, 1'b1, 64'hDEAD_BEEF_8765_4321, 3'd1, 64'h0000_0000_8765_4321}, // R5
        '{5'b11101, 3'd4, 3'b110, 5'b10001, 1'b1, 64'h0000_0000_8765_4321, 3'd1, 64'hFFFF_FFFF_8765_4321}, // R5
        '{5'b11101, 3'd6, 3'b110, 5'b10001, 1'b1, 64'hFFFF_FFFF_7000_0001, 3'd1, 64'h0000_0000_7000_0001}, // R5
        '{5'b11101, 3'd4, 3'b010, 5'b10001, 1'b0, 64'hDEAD_BEEF_8765_4321, 3'd4, 64'h0},                   // R6
        '{5'b11101, 3'd4, 3'b110, 5'b10001, 1'b0, 64'h0000_0000_8765_4321, 3'd4, 64'h0},                   // R6
        '{5'b11101, 3'd6, 3'b100, 5'b00000, 1'b0, 64'h0000_0000_0040_2000, 3'd2, 64'h0000_0000_0040_2000}, // R7
        '{5'b11101, 3'd0, 3'b101, 5'b00000, 1'b0, 64'h0000_0000_0000_0BAD, 3'd2, RA_V},                    // R8
        '{5'b11101, 3'd2, 3'b110, 5'b00000, 1'b1, 64'h0000_0000_0040_3000, 3'd3, 64'h0000_0000_0040_3000}, // R9
        '{5'b11101, 3'd3, 3'b101, 5'b00000, 1'b0, 64'h0000_0000_0040_4000, 3'd4, 64'h0},                   // R10
        '{5'b11101, 3'd1, 3'b011, 5'b10001, 1'b1, 64'h0000_0000_0000_1111, 3'd4, 64'h0},                   // R10
        '{5'b11101, 3'd1, 3'b111, 5'b10001, 1'b1, 64'h0000_0000_0000_2222, 3'd4, 64'h0},                   // R10
        '{5'b11101, 3'd1, 3'b000, 5'b00000, 1'b1, 64'h0000_0000_0000_3333, 3'd4, 64'h0},                   // R10
        '{5'b11101, 3'd1, 3'b100, 5'b00001, 1'b1, 64'h0000_0000_0000_4444, 3'd4, 64'h0},                   // R10
        '{5'b11100, 3'd3, 3'b100, 5'b10001, 1'b1, 64'h0000_0000_0000_0080, 3'd0, 64'h0}                    // R11
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue = 1'b0;
    logic [15:0]     instr = '0;
    logic            mode64 = 1'b0;
    logic [XLEN-1:0] next_pc = NPC;
    logic [2:0]      rd_idx;
    logic [XLEN-1:0] rd_data = '0;
    logic [XLEN-1:0] ra_val = RA_V;
    logic            wb_en;
    logic [2:0]      wb_idx;
    logic [XLEN-1:0] wb_data;
    logic            ra_we;
    logic [XLEN-1:0] ra_wdata;
    logic            br_take;
    logic [XLEN-1:0] br_target;
    logic            illegal;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmp_rr_unit #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .mode64(mode64),
        .next_pc(next_pc), .rd_idx(rd_idx), .rd_data(rd_data), .ra_val(ra_val),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .ra_we(ra_we),
        .ra_wdata(ra_wdata), .br_take(br_take), .br_target(br_target), .illegal(illegal)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input vec_t v);
        case (v.ek)
            3'd1: return (v.sub[1:0] == 2'b10) ? "R5" : (v.sub[2] ? "R2" : "R3");
            3'd2: return (v.sub == 3'b101) ? "R8" : "R7";
            3'd3: return "R9";
            3'd4: return (v.fn == 5'b10001 && v.sub[1:0] == 2'b10) ? "R6" : "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check_flags(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {wb_en, br_take, ra_we, illegal};
        chk(act == exp, req, "flags{wb,br,ra,ill}", 64'(act), 64'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_flags("R1", 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check_flags("R1", 4'b0000);

        // table walk, back to back
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [3:0] ef;
            v = VT[i];
            instr = {v.maj, v.rx, v.sub, v.fn};
            mode64 = v.m64;
            rd_data = v.rsv;
            issue = 1'b1;
            #1;
            chk(rd_idx == v.rx, "R4", "rd_idx", 64'(rd_idx), 64'(v.rx));
            @(posedge clk);
            @(negedge clk);
            ef = {v.ek == 3'd1, (v.ek == 3'd2) || (v.ek == 3'd3), v.ek == 3'd3, v.ek == 3'd4};
            check_flags(req_of(v), ef);
            if (v.ek == 3'd1) begin
                chk(wb_data == v.ed, req_of(v), "wb_data", wb_data, v.ed);
                chk(wb_idx == v.rx, "R4", "wb_idx", 64'(wb_idx), 64'(v.rx));
            end
            if (v.ek == 3'd2 || v.ek == 3'd3)
                chk(br_target == v.ed, req_of(v), "br_target", br_target, v.ed);
            if (v.ek == 3'd3)
                chk(ra_wdata == NPC, "R9", "ra_wdata", ra_wdata, NPC);
        end

        // R4: result lasts one cycle only
        issue = 1'b0;
        @(negedge clk);
        check_flags("R4", 4'b0000);

        // R11: a legal extend without issue does nothing
        instr = {5'b11101, 3'd3, 3'b100, 5'b10001};
        rd_data = 64'h80;
        @(negedge clk);
        check_flags("R11", 4'b0000);

        // R4: result appears exactly one edge after issue
        issue = 1'b1;
        #1;
        check_flags("R4", 4'b0000);
        @(negedge clk);
        issue = 1'b0;
        check_flags("R4", 4'b1000);
        chk(wb_data == 64'hFFFF_FFFF_FFFF_FF80, "R2", "wb_data", wb_data, 64'hFFFF_FFFF_FFFF_FF80);

        // R1: asynchronous reset clears a pending jump result
        instr = {5'b11101, 3'd2, 3'b110, 5'b00000};
        issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        check_flags("R9", 4'b0110);
        rst_n = 1'b0;
        #1;
        check_flags("R1", 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_flags("R1", 4'b0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule